// File: doc/BRIEF.md
# Banked Register Address Mapper

This block sits between a serial register-access master and the on-chip storage. Each access carries a 7-bit register address. The mapper turns that address into a physical storage address and flags which storage region the access targets. Addresses with the top bit set form a fixed region that is decoded straight through. Addresses with the top bit clear fall into a 64-byte window. A 4-bit bank select value places that window at one of 16 physical bank positions.

The block also watches for one specific write. A write to offset zero while the bank select is zero raises a one-cycle internal reset request. The surrounding chip uses this request to restart from its current volatile configuration. It clears the period counter and any stored configuration errors, and it does not fetch settings from non-volatile memory again.

All outputs are registered. Results appear on the clock cycle after the access is presented.

Top module: `bank_addr_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every output is zero.
- R2: An access with `acc_addr` in 0x40..0x7F gives `phys_direct` = 1 and `phys_addr` = {4'b0000, acc_addr[5:0]}, whatever the value of `bank_sel`.
- R3: An access with `acc_addr` in 0x00..0x3F gives `phys_direct` = 0 and `phys_addr` = {bank_sel[3:0], acc_addr[5:0]}, a 10-bit value.
- R4: `phys_valid` equals `acc_en` delayed by one cycle. `phys_we` is `acc_en & acc_we` delayed by one cycle. `phys_wdata` carries the `acc_wdata` of that same access.
- R5: A write (`acc_en`=1, `acc_we`=1) to `acc_addr` 0x00 with `bank_sel` 0 raises `soft_rst` for exactly one cycle, in the cycle after the write.
- R6: A read of 0x00 in bank 0, a write to 0x00 in any nonzero bank, a write to any other address, and a cycle with `acc_en`=0 all leave `soft_rst` low.
- R7: `soft_rst` is never high on two consecutive cycles. Back-to-back qualifying writes give a pulse on every other cycle.
- R8: On a cycle with `acc_en`=0, `phys_addr`, `phys_direct` and `phys_wdata` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe from the serial master |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Register address |
| acc_wdata | input | 8 | Write data |
| bank_sel | input | 4 | Bank placing the low 64-byte window |
| phys_valid | output | 1 | Registered access strobe |
| phys_we | output | 1 | Registered write strobe |
| phys_addr | output | 10 | Physical storage address |
| phys_wdata | output | 8 | Registered write data |
| phys_direct | output | 1 | 1 = fixed region, 0 = banked window |
| soft_rst | output | 1 | One-cycle internal reset request |

## Verification
A wrong region decision or a wrong bank field shows up on `phys_direct` and `phys_addr` in the cycle right after the access. The direct region is driven with nonzero bank values so that any leak of the bank into its address can be seen. A stuck or mis-armed reset detector shows up on `soft_rst` one cycle after the triggering or near-miss access. Runs of consecutive qualifying writes bring out the single-cycle rule. Idle cycles placed between accesses bring out any drift in the held address.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic {
    REGION_BANKED = 1'b0,
    REGION_DIRECT = 1'b1
  } region_e;
endpackage

// File: rtl/bam_region_decode.sv
module bam_region_decode
  import bam_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int OFS_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [OFS_W-1:0]  ofs
);
  always_comb begin
    region = addr[ADDR_W-1] ? REGION_DIRECT : REGION_BANKED;
    ofs    = addr[OFS_W-1:0];
  end
endmodule

// File: rtl/bam_bank_map.sv
module bam_bank_map
  import bam_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int OFS_W  = 6,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  region_e           region,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (region == REGION_DIRECT) phys = {{BANK_W{1'b0}}, ofs};
    else                         phys = {bank, ofs};
  end
endmodule

// File: rtl/bam_reset_detect.sv
module bam_reset_detect #(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 4,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = '0,
  parameter logic [BANK_W-1:0] TRIG_BANK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              pulse
);
  logic hit;

  always_comb begin
    hit = acc_en && acc_we && (addr == TRIG_ADDR) && (bank == TRIG_BANK);
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= hit && !pulse;
  end
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
  import bam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 4,
  parameter int DATA_W = 8,
  localparam int OFS_W  = ADDR_W - 1,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              phys_valid,
  output logic              phys_we,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [DATA_W-1:0] phys_wdata,
  output logic              phys_direct,
  output logic              soft_rst
);
  region_e          region;
  logic [OFS_W-1:0]  ofs;
  logic [PHYS_W-1:0] phys_next;

  bam_region_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (acc_addr),
    .region (region),
    .ofs    (ofs)
  );

  bam_bank_map #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_map (
    .region (region),
    .bank   (bank_sel),
    .ofs    (ofs),
    .phys   (phys_next)
  );

  bam_reset_detect #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .TRIG_ADDR ('0),
    .TRIG_BANK ('0)
  ) u_rstdet (
    .clk    (clk),
    .rst    (rst),
    .acc_en (acc_en),
    .acc_we (acc_we),
    .addr   (acc_addr),
    .bank   (bank_sel),
    .pulse  (soft_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid  <= 1'b0;
      phys_we     <= 1'b0;
      phys_addr   <= '0;
      phys_wdata  <= '0;
      phys_direct <= 1'b0;
    end else begin
      phys_valid <= acc_en;
      phys_we    <= acc_en && acc_we;
      if (acc_en) begin
        phys_addr   <= phys_next;
        phys_wdata  <= acc_wdata;
        phys_direct <= (region == REGION_DIRECT);
      end
    end
  end
endmodule

// File: rtl/bam_checker.sv
module bam_checker #(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 4,
  parameter int DATA_W = 8,
  localparam int OFS_W  = ADDR_W - 1,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [BANK_W-1:0] bank_sel,
  input logic              phys_valid,
  input logic              phys_we,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [DATA_W-1:0] phys_wdata,
  input logic              phys_direct,
  input logic              soft_rst
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !phys_valid && !soft_rst && phys_addr == '0); // R1
  AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (rst) (acc_en && acc_addr[ADDR_W-1]) |=> (phys_direct && phys_addr == {{BANK_W{1'b0}}, $past(acc_addr[OFS_W-1:0])})); // R2
  AST_BANK_MAP: assert property (@(posedge clk) disable iff (rst) (acc_en && !acc_addr[ADDR_W-1]) |=> (!phys_direct && phys_addr == {$past(bank_sel), $past(acc_addr[OFS_W-1:0])})); // R3
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) phys_we |-> phys_valid); // R4
  AST_WDATA_ALIGN: assert property (@(posedge clk) disable iff (rst) acc_en |=> phys_wdata == $past(acc_wdata)); // R4
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst) soft_rst |-> $past(acc_en && acc_we && acc_addr == '0 && bank_sel == '0)); // R5
  AST_NO_RST_READ: assert property (@(posedge clk) disable iff (rst) (acc_en && !acc_we) |=> !soft_rst); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst) soft_rst |=> !soft_rst); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !acc_en |=> $stable(phys_addr) && $stable(phys_direct) && $stable(phys_wdata)); // R8
endmodule

bind bank_addr_mapper bam_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .DATA_W (DATA_W)
) u_bam_checker (
  .clk         (clk),
  .rst         (rst),
  .acc_en      (acc_en),
  .acc_we      (acc_we),
  .acc_addr    (acc_addr),
  .acc_wdata   (acc_wdata),
  .bank_sel    (bank_sel),
  .phys_valid  (phys_valid),
  .phys_we     (phys_we),
  .phys_addr   (phys_addr),
  .phys_wdata  (phys_wdata),
  .phys_direct (phys_direct),
  .soft_rst    (soft_rst)
);

// File: tb/tb_bank_addr_mapper.sv
`timescale 1ns/1ps
module tb_bank_addr_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       acc_we = 1'b0;
  logic [6:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [3:0] bank_sel = '0;
  logic       phys_valid, phys_we, phys_direct, soft_rst;
  logic [9:0] phys_addr;
  logic [7:0] phys_wdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_addr_mapper dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .bank_sel(bank_sel),
    .phys_valid(phys_valid), .phys_we(phys_we), .phys_addr(phys_addr),
    .phys_wdata(phys_wdata), .phys_direct(phys_direct), .soft_rst(soft_rst)
  );

  typedef struct {
    logic       valid;
    logic       we;
    logic [9:0] addr;
    logic [7:0] wdata;
    logic       direct;
    logic       pulse;
    string      tag_map;
    string      tag_rst;
  } exp_t;

  exp_t q[$];
  logic [9:0] m_addr = '0;
  logic [7:0] m_wdata = '0;
  logic       m_direct = 1'b0;
  logic       m_pulse = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one cycle of stimulus and queues the expected result
  task automatic drive(input logic en, input logic we, input logic [6:0] a,
                       input logic [7:0] d, input logic [3:0] b,
                       input string tmap, input string trst);
    exp_t e;
    logic hit;
    @(negedge clk);
    acc_en = en; acc_we = we; acc_addr = a; acc_wdata = d; bank_sel = b;
    hit = en && we && a == 7'h00 && b == 4'h0;
    m_pulse = hit && !m_pulse;
    if (en) begin
      m_direct = a[6];
      m_addr   = a[6] ? {4'h0, a[5:0]} : {b, a[5:0]};
      m_wdata  = d;
    end
    e.valid = en; e.we = en && we; e.addr = m_addr; e.wdata = m_wdata;
    e.direct = m_direct; e.pulse = m_pulse; e.tag_map = tmap; e.tag_rst = trst;
    q.push_back(e);
  endtask

  // Monitor: compares the front of the queue after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R4", "phys_valid", 32'(phys_valid), 32'(e.valid));
        check("R4", "phys_we", 32'(phys_we), 32'(e.we));
        check(e.tag_map, "phys_addr", 32'(phys_addr), 32'(e.addr));
        check(e.tag_map, "phys_direct", 32'(phys_direct), 32'(e.direct));
        check("R4", "phys_wdata", 32'(phys_wdata), 32'(e.wdata));
        check(e.tag_rst, "soft_rst", 32'(soft_rst), 32'(e.pulse));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while reset is held
    check("R1", "phys_valid", 32'(phys_valid), 0);
    check("R1", "phys_addr", 32'(phys_addr), 0);
    check("R1", "soft_rst", 32'(soft_rst), 0);
    check("R1", "phys_direct", 32'(phys_direct), 0);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1", "phys_valid after release", 32'(phys_valid), 0);
    check("R1", "phys_wdata after release", 32'(phys_wdata), 0);

    // R2: fixed region ignores bank select
    drive(1, 0, 7'h40, 8'h11, 4'hF, "R2", "R6");
    drive(1, 1, 7'h7F, 8'h22, 4'hA, "R2", "R6");
    drive(1, 1, 7'h55, 8'h33, 4'h0, "R2", "R6");
    // R3: banked window
    drive(1, 0, 7'h3F, 8'h44, 4'hF, "R3", "R6");
    drive(1, 1, 7'h15, 8'h55, 4'h7, "R3", "R6");
    drive(1, 0, 7'h01, 8'h66, 4'h0, "R3", "R6");
    // R8: idle keeps last values
    drive(0, 1, 7'h20, 8'h99, 4'h3, "R8", "R6");
    drive(0, 0, 7'h7E, 8'h98, 4'h9, "R8", "R6");
    // R5: qualifying write
    drive(1, 1, 7'h00, 8'hA5, 4'h0, "R3", "R5");
    drive(0, 0, 7'h00, 8'h00, 4'h0, "R8", "R5");
    // R6: near misses
    drive(1, 0, 7'h00, 8'h01, 4'h0, "R3", "R6");
    drive(1, 1, 7'h00, 8'h02, 4'h1, "R3", "R6");
    drive(1, 1, 7'h00, 8'h03, 4'hF, "R3", "R6");
    drive(1, 1, 7'h40, 8'h04, 4'h0, "R2", "R6");
    drive(0, 1, 7'h00, 8'h05, 4'h0, "R8", "R6");
    // R7: back-to-back qualifying writes -> high, low, high
    drive(1, 1, 7'h00, 8'hB0, 4'h0, "R3", "R7");
    drive(1, 1, 7'h00, 8'hB1, 4'h0, "R3", "R7");
    drive(1, 1, 7'h00, 8'hB2, 4'h0, "R3", "R7");
    drive(0, 0, 7'h00, 8'h00, 4'h0, "R8", "R7");
    // R3: sweep every bank at a mid offset
    for (int b = 0; b < 16; b++) drive(1, 1, 7'h2A, 8'(b), 4'(b), "R3", "R6");
    drive(0, 0, 7'h00, 8'h00, 4'h0, "R8", "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule